// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Modulator with Third-Harmonic Injection

This block produces three PWM gate-control levels, one per phase of a three-phase bridge. A symmetric triangle carrier counts up and down at the switching rate. Three low-frequency sine references, spaced a third of a turn apart, are each compared against that carrier. The reference amplitude follows a depth input, and that amplitude sets the fundamental output voltage. Full depth is reached when the reference peak touches the carrier peak.

An optional third-harmonic term can be added to every reference. It is read from the same sine table at three times each phase's angle and weighted to about 15 percent. The term is common to all three phases, so it cancels in the line-to-line voltages. It flattens each reference's crest, which lets the depth rise by roughly 15 percent before the carrier limits are reached. Any reference that still overshoots is clamped to the carrier range rather than wrapping.

The integrator sets the carrier half-period in clock cycles and a phase step per carrier period. These together fix the output frequency. An enclosing controller is expected to hold these settings or change them slowly. Dead time, space-vector patterns and output filtering belong to other blocks.

Top module: `pwm3h_mod`

## Requirements
- R1: While `rst_ni` is low, every bit of `pwm_o` is 0. This holds from the moment reset asserts, without waiting for a clock edge.
- R2: The carrier counts 0, 1, …, P, P−1, …, 1, 0, 1, … with P = `period_i`, sampled every cycle (P ≥ 2). It goes down on the cycle after it reaches or exceeds P, and up on the cycle after it reaches 0. When the carrier is 0, the down count turns around to 1. The carrier starts at 0 counting up.
- R3: A PW-bit phase accumulator (PW = 16) starts at 0. It adds `step_i` (modulo 2^PW) on each clock where the carrier is 0, and holds on every other clock.
- R4: The sine sample of a PW-bit angle a uses i = a >> (PW−8), a 256-step index. The sample is round(2047·sin(2π(i+0.5)/256)), rounded half away from zero, giving values in −2047…2047.
- R5: Phase k (k = 0, 1, 2) adds an offset of floor((k·2^PW+1)/3) to the accumulator, modulo 2^PW. These offsets are 0, 21845 and 43691. Bit k of `pwm_o` belongs to phase k.
- R6: The harmonic angle of phase k is three times its fundamental angle, modulo 2^PW. When `inj_en_i` is 1, the term floor(5·s3/32) is added to the fundamental sample, where s3 is the sample at the harmonic angle. When `inj_en_i` is 0, nothing is added.
- R7: Let D = `depth_i`, where 128 means unity gain. The reference is floor(P/2) + floor(sum·D·P / 2^19). All floors round toward minus infinity.
- R8: The reference register takes the value from R7, computed from the phase, depth, injection and period present on a clock edge. On the next edge, `pwm_o[k]` loads 1 when that registered reference is greater than the carrier value of the same cycle, and 0 otherwise.
- R9: A reference above P is clamped to P, and one below 0 is clamped to 0. It never wraps.
- R10: With D = 0, every reference equals floor(P/2). With P = 100, each output is then high for 99 of every 200 cycles, and all three outputs are identical.
- R11: Release of `rst_ni` passes through a two-stage synchronizer. The carrier, phase, reference and output registers stay in their reset state for the first two clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| period_i | input | CW (10) | Carrier peak value P, in clock cycles |
| step_i | input | PW (16) | Phase step added once per carrier period |
| depth_i | input | MW (8) | Modulation depth; 128 is unity |
| inj_en_i | input | 1 | Adds the third-harmonic term to all references |
| pwm_o | output | 3 | Registered comparison result per phase |

## Verification
The assertions check on every cycle four things:
- the carrier only moves by one step, or rests at zero;
- the phase only moves on a carrier-zero cycle;
- no registered reference exceeds the period it was built from;
- a zero reference never drives its output high.

Whether the sine values, the 120° offsets, the harmonic weighting, the scaling arithmetic and the one-cycle compare timing are right can only be seen by the bench. Its behavioural model recomputes every reference from the formulas with real-valued sine. It compares all three outputs on every cycle, across varied depths, steps, periods and injection settings, and across a reset taken mid-run.

// File: rtl/pwm3h_pkg.sv
package pwm3h_pkg;

  // three-phase bridge
  localparam int NPH = 3;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

endpackage

// File: rtl/pwm3h_carrier.sv
module pwm3h_carrier
  import pwm3h_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  dir_e          dir_q, dir_d;

  // next state of the up/down triangle
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (dir_q == DIR_UP) begin
      if (cnt_q >= period_i) begin
        dir_d = DIR_DOWN;
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else begin
      if (cnt_q == '0) begin
        dir_d = DIR_UP;
        cnt_d = (period_i != '0) ? CW'(1) : '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pwm3h_phase.sv
module pwm3h_phase
  import pwm3h_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic [PW-1:0]           step_i,
  output logic [PW-1:0]           acc_o,
  output logic [NPH-1:0][PW-1:0]  fund_o,
  output logic [NPH-1:0][PW-1:0]  harm_o
);

  logic [PW-1:0] acc_q, acc_d;

  // accumulator with explicit advance enable
  always_comb begin
    acc_d = acc_q;
    if (adv_i) acc_d = acc_q + step_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // per-phase angle: one third of a turn apart, harmonic at triple angle
  for (genvar k = 0; k < NPH; k++) begin : g_ph
    localparam longint OFFL = (longint'(k) * (longint'(1) << PW) + 1) / 3;
    localparam logic [PW-1:0] OFF = PW'(OFFL);
    logic [PW-1:0] ang;
    assign ang       = acc_q + OFF;
    assign fund_o[k] = ang;
    assign harm_o[k] = ang * PW'(3);
  end

endmodule

// File: rtl/pwm3h_sine.sv
module pwm3h_sine #(
  parameter int PW = 16,
  parameter int QA = 6,
  parameter int SW = 12
) (
  input  logic [PW-1:0]        ang_i,
  output logic signed [SW-1:0] samp_o
);

  localparam int QN   = 2 ** QA;
  localparam int SMAX = 2 ** (SW - 1) - 1;
  localparam int LSB  = PW - QA - 2;

  // quarter-wave magnitude at half-step offsets, computed at elaboration
  function automatic int quarter_val(int k);
    real arg;
    arg = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * QN);
    return $rtoi(real'(SMAX) * $sin(arg) + 0.5);
  endfunction

  logic [SW-2:0] qtab [QN];

  for (genvar g = 0; g < QN; g++) begin : g_tab
    localparam int QV = quarter_val(g);
    assign qtab[g] = QV[SW-2:0];
  end

  logic [1:0]    quad;
  logic [QA-1:0] addr;
  logic [SW-2:0] mag;
  logic          unused_lsb;

  assign quad       = ang_i[PW-1 -: 2];
  assign addr       = quad[0] ? ~ang_i[PW-3 -: QA] : ang_i[PW-3 -: QA];
  assign mag        = qtab[addr];
  assign unused_lsb = ^ang_i[LSB > 0 ? LSB-1 : 0];

  always_comb begin
    if (quad[1]) samp_o = -$signed({1'b0, mag});
    else         samp_o =  $signed({1'b0, mag});
  end

endmodule

// File: rtl/pwm3h_ref.sv
module pwm3h_ref #(
  parameter int CW      = 10,
  parameter int SW      = 12,
  parameter int MW      = 8,
  parameter int H_NUM   = 5,
  parameter int H_SHIFT = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [SW-1:0] fund_i,
  input  logic signed [SW-1:0] harm_i,
  input  logic                 inj_i,
  input  logic [MW-1:0]        depth_i,
  input  logic [CW-1:0]        period_i,
  output logic [CW-1:0]        ref_o
);

  localparam int SUMW = SW + 1;
  localparam int MULW = SUMW + MW + 1;
  localparam int PRW  = MULW + CW + 1;
  localparam int SHR  = SW + MW - 1;
  localparam logic signed [PRW-1:0] HN_X = PRW'(H_NUM);

  logic signed [PRW-1:0] f_x, h3_x, h_x, sum_x, dep_x, per_x;
  logic signed [PRW-1:0] prod_x, off_x, mid_x, lvl_x;
  logic [CW-1:0]         ref_q, ref_d;

  assign f_x   = {{(PRW-SW){fund_i[SW-1]}}, fund_i};
  assign h3_x  = {{(PRW-SW){harm_i[SW-1]}}, harm_i};
  assign dep_x = {{(PRW-MW){1'b0}}, depth_i};
  assign per_x = {{(PRW-CW){1'b0}}, period_i};

  // weighted harmonic, summed, scaled by depth and period
  assign h_x    = (h3_x * HN_X) >>> H_SHIFT;
  assign sum_x  = inj_i ? (f_x + h_x) : f_x;
  assign prod_x = sum_x * dep_x * per_x;
  assign off_x  = prod_x >>> SHR;
  assign mid_x  = per_x >>> 1;
  assign lvl_x  = mid_x + off_x;

  // clamp to the carrier range
  always_comb begin
    if (lvl_x < 0)          ref_d = '0;
    else if (lvl_x > per_x) ref_d = period_i;
    else                    ref_d = lvl_x[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_d;
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/pwm3h_mod.sv
module pwm3h_mod
  import pwm3h_pkg::*;
#(
  parameter int CW      = 10,
  parameter int PW      = 16,
  parameter int QA      = 6,
  parameter int SW      = 12,
  parameter int MW      = 8,
  parameter int H_NUM   = 5,
  parameter int H_SHIFT = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  period_i,
  input  logic [PW-1:0]  step_i,
  input  logic [MW-1:0]  depth_i,
  input  logic           inj_en_i,
  output logic [NPH-1:0] pwm_o
);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  logic [CW-1:0]           car_cnt;
  logic                    car_zero;
  logic [PW-1:0]           ph_acc;
  logic [NPH-1:0][PW-1:0]  ang_f, ang_h;
  logic [NPH-1:0][CW-1:0]  ref_q;
  logic [NPH-1:0]          pwm_d, pwm_q;

  pwm3h_carrier #(.CW(CW)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .period_i (period_i),
    .cnt_o    (car_cnt),
    .zero_o   (car_zero)
  );

  pwm3h_phase #(.PW(PW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .adv_i  (car_zero),
    .step_i (step_i),
    .acc_o  (ph_acc),
    .fund_o (ang_f),
    .harm_o (ang_h)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    logic signed [SW-1:0] s_f, s_h;

    pwm3h_sine #(.PW(PW), .QA(QA), .SW(SW)) u_sin_f (
      .ang_i  (ang_f[k]),
      .samp_o (s_f)
    );

    pwm3h_sine #(.PW(PW), .QA(QA), .SW(SW)) u_sin_h (
      .ang_i  (ang_h[k]),
      .samp_o (s_h)
    );

    pwm3h_ref #(
      .CW(CW), .SW(SW), .MW(MW), .H_NUM(H_NUM), .H_SHIFT(H_SHIFT)
    ) u_ref (
      .clk_i    (clk_i),
      .rst_ni   (rst_int_n),
      .fund_i   (s_f),
      .harm_i   (s_h),
      .inj_i    (inj_en_i),
      .depth_i  (depth_i),
      .period_i (period_i),
      .ref_o    (ref_q[k])
    );

    assign pwm_d[k] = (ref_q[k] > car_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) pwm_q <= '0;
    else            pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm3h_chk.sv
module pwm3h_chk
  import pwm3h_pkg::*;
#(
  parameter int CW = 10,
  parameter int PW = 16
) (
  input logic                   clk_i,
  input logic                   rst_n,
  input logic [CW-1:0]          period_i,
  input logic [CW-1:0]          cnt,
  input logic [PW-1:0]          phase,
  input logic [NPH-1:0][CW-1:0] ref_q,
  input logic [NPH-1:0]         pwm_o
);

  // R2
  carrier_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1)) ||
    (cnt == '0 && $past(cnt) == '0));

  // R3
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(phase) |-> ($past(cnt) == '0));

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    // R9
    ref_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      ref_q[k] <= $past(period_i));

    // R8
    zero_ref_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      ($past(ref_q[k]) == '0) |-> !pwm_o[k]);
  end

endmodule

bind pwm3h_mod pwm3h_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_int_n),
  .period_i (period_i),
  .cnt      (car_cnt),
  .phase    (ph_acc),
  .ref_q    (ref_q),
  .pwm_o    (pwm_o)
);

// File: tb/pwm3h_mod_tb.sv
`timescale 1ns/1ps
module pwm3h_mod_tb;

  localparam int CW = 10;
  localparam int PW = 16;
  localparam int MW = 8;
  localparam longint PMASK = (longint'(1) << PW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] period;
  logic [PW-1:0] step;
  logic [MW-1:0] depth;
  logic          inj;
  logic [2:0]    pwm;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pwm3h_mod u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .period_i (period),
    .step_i   (step),
    .depth_i  (depth),
    .inj_en_i (inj),
    .pwm_o    (pwm)
  );

  // behavioural reference state
  int     m_sync;
  longint m_cnt, m_ph;
  bit     m_up;
  longint m_ref [3];
  bit     m_out [3];

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R4 sample
  function automatic longint sine_at(longint a);
    longint i;
    real v;
    i = (a >> (PW - 8)) & 255;
    v = 2047.0 * $sin(6.283185307179586 * (real'(i) + 0.5) / 256.0);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(-v + 0.5));
  endfunction

  function automatic longint ref_of(int k);
    longint a, s1, s3, sum, prod, lvl, p;
    p    = longint'(period);
    a    = (m_ph + (longint'(k) * (longint'(1) << PW) + 1) / 3) & PMASK;
    s1   = sine_at(a);
    s3   = sine_at((a * 3) & PMASK);
    sum  = s1 + (inj ? ((s3 * 5) >>> 5) : 0);
    prod = sum * longint'(depth) * p;
    lvl  = (p >>> 1) + (prod >>> 19);
    if (lvl < 0) lvl = 0;
    if (lvl > p) lvl = p;
    return lvl;
  endfunction

  task automatic model_reset();
    m_sync = 0; m_cnt = 0; m_ph = 0; m_up = 1;
    for (int k = 0; k < 3; k++) begin m_ref[k] = 0; m_out[k] = 0; end
  endtask

  task automatic model_step();
    longint nref [3];
    if (!rst_n) begin
      model_reset();
      return;
    end
    if (m_sync >= 2) begin
      for (int k = 0; k < 3; k++) nref[k] = ref_of(k);
      for (int k = 0; k < 3; k++) m_out[k] = (m_ref[k] > m_cnt);
      for (int k = 0; k < 3; k++) m_ref[k] = nref[k];
      if (m_cnt == 0) m_ph = (m_ph + longint'(step)) & PMASK;
      if (m_up) begin
        if (m_cnt >= longint'(period)) begin
          m_up = 0;
          m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
        end else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin
          m_up = 1;
          m_cnt = (period != 0) ? 1 : 0;
        end else m_cnt = m_cnt - 1;
      end
    end
    if (m_sync < 2) m_sync++;
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int k = 0; k < 3; k++)
      check(pwm[k] === m_out[k], req, longint'(pwm[k]), longint'(m_out[k]));
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) cycle(req);
  endtask

  task automatic setup(int p, int s, int d, bit h);
    period = CW'(p); step = PW'(s); depth = MW'(d); inj = h;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL R2: actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int highs;
    model_reset();
    rst_n = 1'b0;
    setup(100, 1024, 128, 1'b0);
    @(negedge clk);
    check(pwm == 3'b000, "R1", longint'(pwm), 0);
    run(4, "R1");
    rst_n = 1'b1;
    run(3, "R11");
    // plain sine at unity depth
    run(13000, "R4");
    // harmonic injected, depth above unity
    setup(100, 1024, 147, 1'b1);
    run(13000, "R6");
    // overmodulated, clamped
    setup(64, 2048, 255, 1'b0);
    run(5000, "R9");
    // scaling with injection, uneven depth
    setup(90, 1500, 77, 1'b1);
    run(4000, "R7");
    // phase spacing under a fast step
    setup(40, 9000, 128, 1'b0);
    run(3000, "R5");
    // large step advance
    setup(30, 30000, 100, 1'b1);
    run(2000, "R3");
    // shrink period mid-count
    setup(100, 1024, 128, 1'b0);
    run(150, "R2");
    setup(10, 3000, 200, 1'b1);
    run(3000, "R2");
    // tight carrier, compare timing
    setup(7, 4000, 128, 1'b1);
    run(2000, "R8");
    // zero depth: fixed half-period duty
    setup(100, 1024, 0, 1'b1);
    run(400, "R10");
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      cycle("R10");
      if (pwm[0]) highs++;
      check(pwm == 3'b000 || pwm == 3'b111, "R10", longint'(pwm), longint'({3{pwm[0]}}));
    end
    check(highs == 99, "R10", highs, 99);
    // reset taken mid-run
    setup(100, 1024, 128, 1'b1);
    run(777, "R8");
    rst_n = 1'b0;
    #1;
    check(pwm == 3'b000, "R1", longint'(pwm), 0);
    run(3, "R1");
    rst_n = 1'b1;
    run(2, "R11");
    check(pwm == 3'b000, "R11", longint'(pwm), 0);
    run(3000, "R4");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule